// File: doc/BRIEF.md
# Serial Flash Read Slave

This block is the read side of a serial flash device, seen from an SPI master. The master pulls chip select low. It then clocks in an 8-bit command and a 24-bit byte address, most significant bit first. If the command is the read code, the slave sends the byte stored at that address, most significant bit first. As long as chip select stays low and the serial clock keeps toggling, the slave keeps sending bytes from the next locations. An internal pointer advances after every byte and wraps at the top of the array.

The data sits in a small internal byte array. A parallel load port on the system clock fills it. The serial pins are sampled by the system clock, which must run well above the serial clock rate. The block works in SPI mode 0: the clock idles low, the master input is sampled on the rising edge, and the slave output changes on the falling edge. The output pin is reported as a data bit together with a drive enable. A low enable stands for high impedance.

Top module: `serial_read_slave`

## Requirements
- R1: The first 8 bits after chip select falls, taken from `mosi` on rising `sclk` and MSB first, form the command. The value 0x03 starts a read, and the next 24 bits are the start address, MSB first.
- R2: Read data leaves on `miso` MSB first (D7 down to D0). Each bit is updated on a falling `sclk` edge. D7 of the first byte is present after the falling edge that follows the last address bit.
- R3: While chip select stays low, every further group of 8 clocks returns the byte at the next address. The internal pointer advances by one after each byte.
- R4: After location 2^AW-1 the pointer returns to location 0.
- R5: Only the low AW bits of the 24-bit address select the location. The upper bits have no effect on the data returned.
- R6: Any command other than 0x03 keeps `miso_oe` low until chip select rises, however many clocks follow.
- R7: Chip select high returns the command and address parser to its start in any state. `miso_oe` is low from the first system clock edge that sees chip select high, and a transaction aborted mid-address leaves the next one unaffected.
- R8: Raising chip select after D0 ends the read after one byte. The next transaction starts at its own address, not the continued one.
- R9: With `ld_we` high at a rising `clk`, `ld_data` is stored at location `ld_addr`, and a later read returns it.
- R10: While and after reset, `miso_oe` and `miso` are 0.
- R11: `miso_oe` is high only in the data phase, from the first data bit until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the master (mode 0) |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Drive enable for `miso`; low means high impedance |
| ld_we | input | 1 | Load strobe for the byte array |
| ld_addr | input | AW | Array location to load |
| ld_data | input | DW | Byte to load |

## Verification
The assertions assume that `cs_n`, `sclk` and `mosi` are synchronous to `clk` and that each `sclk` level is held for at least two system clocks, so that every serial edge is seen exactly once. They also assume that chip select only changes while `sclk` is low, and that the array is not reloaded during a read. The bench drives all serial pins on the falling edge of `clk` and holds every `sclk` level for two cycles. It moves `cs_n` only with `sclk` low and preloads the array only between transactions.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_REJ  = 2'd3
    } sfr_state_e;

endpackage

// File: rtl/sfr_edge.sv
module sfr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);

    logic sclk_d, sclk_q;

    always_comb begin
        sclk_d = sclk;
        rise   = sclk & ~sclk_q;
        fall   = ~sclk & sclk_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_d;
    end

endmodule

// File: rtl/sfr_array.sv
module sfr_array #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    always_comb rdata = mem_q[raddr];

endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
    import sfr_pkg::*;
#(
    parameter int              AW   = 6,
    parameter int              DW   = 8,
    parameter int              CMDW = 8,
    parameter int              ADRW = 24,
    parameter logic [CMDW-1:0] OPC  = 8'h03
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          mosi,
    input  logic          rise,
    input  logic          fall,
    input  logic [DW-1:0] rd_byte,
    output logic [AW-1:0] ptr,
    output sfr_state_e    state,
    output logic          miso,
    output logic          miso_oe
);

    localparam int SHW = ((AW > CMDW) ? AW : CMDW) - 1;
    localparam int CW  = $clog2(ADRW);
    localparam int BW  = $clog2(DW);

    typedef struct packed {
        sfr_state_e    state;
        logic [CW-1:0] cnt;
        logic [SHW-1:0] sh;
        logic [AW-1:0] ptr;
        logic [DW-1:0] obyte;
        logic [BW-1:0] bitc;
        logic          miso;
        logic          oe;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cs_n) begin
            r_d.state = ST_CMD;
            r_d.cnt   = '0;
            r_d.bitc  = '0;
            r_d.oe    = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_CMD: begin
                    if (rise) begin
                        r_d.sh = {r_q.sh[SHW-2:0], mosi};
                        if (r_q.cnt == CW'(CMDW - 1)) begin
                            r_d.cnt   = '0;
                            r_d.state = ({r_q.sh[CMDW-2:0], mosi} == OPC) ? ST_ADDR : ST_REJ;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    if (rise) begin
                        r_d.sh = {r_q.sh[SHW-2:0], mosi};
                        if (r_q.cnt == CW'(ADRW - 1)) begin
                            r_d.ptr   = {r_q.sh[AW-2:0], mosi};
                            r_d.cnt   = '0;
                            r_d.bitc  = '0;
                            r_d.state = ST_DATA;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (fall) begin
                        r_d.oe = 1'b1;
                        if (r_q.bitc == '0) begin
                            r_d.miso  = rd_byte[DW-1];
                            r_d.obyte = rd_byte << 1;
                            r_d.ptr   = r_q.ptr + 1'b1;
                        end else begin
                            r_d.miso  = r_q.obyte[DW-1];
                            r_d.obyte = r_q.obyte << 1;
                        end
                        r_d.bitc = (r_q.bitc == BW'(DW - 1)) ? '0 : r_q.bitc + 1'b1;
                    end
                end
                default: ; // ST_REJ: wait for chip select to rise
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_CMD, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        ptr     = r_q.ptr;
        state   = r_q.state;
        miso    = r_q.miso;
        miso_oe = r_q.oe;
    end

endmodule

// File: rtl/serial_read_slave.sv
module serial_read_slave
    import sfr_pkg::*;
#(
    parameter int              AW   = 6,
    parameter int              DW   = 8,
    parameter logic [7:0]      OPC  = 8'h03
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          mosi,
    output logic          miso,
    output logic          miso_oe,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data
);

    localparam int CMDW = 8;
    localparam int ADRW = 24;

    logic          sclk_rise, sclk_fall;
    logic [DW-1:0] rd_byte;
    logic [AW-1:0] ptr_w;
    sfr_state_e    st_w;

    sfr_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    sfr_array #(.AW(AW), .DW(DW)) u_array (
        .clk   (clk),
        .we    (ld_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (ptr_w),
        .rdata (rd_byte)
    );

    sfr_ctrl #(
        .AW   (AW),
        .DW   (DW),
        .CMDW (CMDW),
        .ADRW (ADRW),
        .OPC  (OPC)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .mosi    (mosi),
        .rise    (sclk_rise),
        .fall    (sclk_fall),
        .rd_byte (rd_byte),
        .ptr     (ptr_w),
        .state   (st_w),
        .miso    (miso),
        .miso_oe (miso_oe)
    );

endmodule

// File: rtl/serial_read_slave_chk.sv
module serial_read_slave_chk
    import sfr_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          sclk,
    input logic          miso,
    input logic          miso_oe,
    input sfr_state_e    st,
    input logic [AW-1:0] ptr
);

    logic sclk_ck;
    logic fall_ck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_ck <= 1'b0;
        else        sclk_ck <= sclk;
    end

    always_comb fall_ck = ~sclk & sclk_ck;

    // R7
    cs_high_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !miso_oe);

    // R2
    miso_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> $past(fall_ck));

    // R6
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REJ) |-> !miso_oe);

    // R11
    oe_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> (st == ST_DATA));

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && $past(st) == ST_DATA && ptr != $past(ptr))
        |-> ptr == AW'($past(ptr) + 1'b1));

    // R10
    always_comb begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!miso_oe || $isunknown(miso_oe));
        end
    end

endmodule

bind serial_read_slave serial_read_slave_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .miso    (miso),
    .miso_oe (miso_oe),
    .st      (st_w),
    .ptr     (ptr_w)
);

// File: tb/serial_read_slave_test.sv
module serial_read_slave_test;

    localparam int AW    = 6;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int NVEC  = 6;

    // {start address, byte count}
    localparam logic [31:0] VEC [NVEC] = '{
        {24'h000000, 8'd3},
        {24'h00001E, 8'd4},
        {24'h00003E, 8'd4},
        {24'hABCD05, 8'd2},
        {24'h000020, 8'd1},
        {24'hFFFFFF, 8'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b0;
    logic          mosi = 1'b0;
    logic          miso;
    logic          miso_oe;
    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;

    logic [DW-1:0] model [DEPTH];
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    serial_read_slave #(.AW(AW), .DW(DW)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .mosi    (mosi),
        .miso    (miso),
        .miso_oe (miso_oe),
        .ld_we   (ld_we),
        .ld_addr (ld_addr),
        .ld_data (ld_data)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 29) + 7) ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            mosi = tx[i];
            @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            @(negedge clk);
            @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic sel();
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic desel();
        @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic header(input logic [7:0] cmd, input logic [23:0] a);
        logic [7:0] rx;
        xfer(cmd, rx);
        xfer(a[23:16], rx);
        xfer(a[15:8], rx);
        xfer(a[7:0], rx);
    endtask

    task automatic load(input int a, input logic [7:0] v);
        @(negedge clk);
        ld_we   = 1'b1;
        ld_addr = AW'(a);
        ld_data = v;
        model[a] = v;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] rx;
        logic [7:0] exp;
        int         a;
        string      tag;

        repeat (3) @(negedge clk);
        // R10: outputs quiet during and after reset
        check(miso_oe == 1'b0, "R10 oe in reset", int'(miso_oe), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(miso_oe == 1'b0 && miso == 1'b0, "R10 outputs after reset",
              int'({miso_oe, miso}), 0);

        // R9: preload the whole array through the load port
        for (int i = 0; i < DEPTH; i++) load(i, pat(i));

        // Table walk: R1 R2 R3 R4 R5 R11
        for (int v = 0; v < NVEC; v++) begin
            a = int'(VEC[v][31:8]) % DEPTH;
            if (VEC[v][31:8+AW] != '0)                tag = "R5 upper address bits";
            else if (a + int'(VEC[v][7:0]) > DEPTH)   tag = "R4 wrap";
            else                                      tag = "R3 sequential";
            sel();
            header(8'h03, VEC[v][31:8]);
            for (int k = 0; k < int'(VEC[v][7:0]); k++) begin
                xfer(8'h00, rx);
                exp = model[(a + k) % DEPTH];
                check(rx == exp, tag, int'(rx), int'(exp));
                check(miso_oe == 1'b1, "R11 oe in data", int'(miso_oe), 1);
            end
            desel();
            check(miso_oe == 1'b0, "R7 oe after cs high", int'(miso_oe), 0);
        end

        // R1 R2: single read, MSB-first byte with D7 present on the first clock
        sel();
        header(8'h03, 24'h000011);
        xfer(8'hFF, rx);
        check(rx == model[17], "R2 msb first byte", int'(rx), int'(model[17]));
        desel();

        // R8: one-byte read then restart at the same address
        sel();
        header(8'h03, 24'h000007);
        xfer(8'h00, rx);
        desel();
        sel();
        header(8'h03, 24'h000007);
        xfer(8'h00, rx);
        check(rx == model[7], "R8 restart at own address", int'(rx), int'(model[7]));
        desel();

        // R6: foreign command keeps the output off
        sel();
        header(8'h0B, 24'h000004);
        xfer(8'h00, rx);
        check(miso_oe == 1'b0, "R6 oe after foreign cmd byte 1", int'(miso_oe), 0);
        xfer(8'h03, rx);
        check(miso_oe == 1'b0, "R6 oe after foreign cmd byte 2", int'(miso_oe), 0);
        desel();

        // R7: abort during the address phase, then a clean read
        sel();
        xfer(8'h03, rx);
        xfer(8'h00, rx);
        desel();
        check(miso_oe == 1'b0, "R7 oe after abort", int'(miso_oe), 0);
        sel();
        header(8'h03, 24'h000005);
        xfer(8'h00, rx);
        check(rx == model[5], "R7 read after abort", int'(rx), int'(model[5]));
        desel();

        // R9: overwrite one location and read it back
        load(10, 8'hC3);
        sel();
        header(8'h03, 24'h00000A);
        xfer(8'h00, rx);
        check(rx == 8'hC3, "R9 reloaded byte", int'(rx), 8'hC3);
        xfer(8'h00, rx);
        check(rx == model[11], "R3 byte after reloaded one", int'(rx), int'(model[11]));
        desel();

        finish_run();
    end

endmodule